// File: doc/BRIEF.md
# Dual-Side Mailbox Message Unit

This block joins two processor sides, called A and B, that share one clock. Each side has a small word-addressed register port. A side hands a 32-bit word to its peer by writing one of four outgoing mailbox registers. The word then appears in the same-numbered incoming register on the other side.

Each channel has its own handshake. A sender writes only when that channel's empty flag is set. A receiver reads only when its full flag is set, and the read frees the slot for the sender again. Each side can also raise a doorbell on the peer through request bits in its control word, and it passes a 3-bit flag value that the peer sees in its status word. Each side has one level interrupt output. It combines incoming-full, outgoing-empty and doorbell-pending, each gated by its own per-channel enable.

Top module: `mbox_unit`

## Requirements
- R1: After reset every outgoing-empty flag is set, every incoming-full and doorbell-pending flag is clear, the control words are zero, both interrupt outputs are low and both read-data outputs are zero.
- R2: Word addresses are 0-3 for outgoing channels 0-3, 4-7 for incoming channels 0-3, 8 for status and 9 for control. Read data appears on the cycle after the read strobe and holds while no read is made.
- R3: Writing outgoing register n clears the writer's empty flag (status bit 23-n) and sets the peer's full flag (status bit 27-n). The word can then be read at the peer's incoming register n.
- R4: Reading incoming register n while it is full clears that side's full flag and sets the sender's empty flag n again.
- R5: A write to outgoing register n while its empty flag is clear is discarded, and the word already held is delivered unchanged.
- R6: Writing 1 to control bit 19-n sets doorbell-pending bit 31-n in the peer's status. These request bits read back as zero. Writing 1 to a status bit 31-n clears that pending flag, and a new request in the same cycle takes priority.
- R7: A side's interrupt output goes high one cycle after any channel n has full with control bit 27-n set, empty with control bit 23-n set, or pending with control bit 31-n set. It goes low one cycle after no such term remains.
- R8: Control bits 2:0 written on one side are readable in the peer's status bits 2:0.
- R9: Control bits 31:20 and 3:0 read back as last written. All other control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 1 | Side A access select |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A registered read data |
| a_irq | output | 1 | Side A interrupt |
| b_sel | input | 1 | Side B access select |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B registered read data |
| b_irq | output | 1 | Side B interrupt |

## Verification
The message path is swept over every channel in both directions. Each word is derived from the channel and the direction, so a word routed to the wrong channel or the wrong side gives a different value. Each transfer writes a second, inverted word while the slot is still full. This separates discard from overwrite. Status is read on both sides before and after each delivery to catch flags that are swapped in bit order. Each interrupt source is then enabled alone, together with doorbells sent in each direction and flag values passed in each direction, so that a wrong enable field or a missing clear shows up on the interrupt pin.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MB_CH  = 4;
  localparam int unsigned MB_DW  = 32;
  localparam int unsigned MB_AW  = 4;
  localparam int unsigned MB_FLW = 3;
endpackage

// File: rtl/mbox_dir.sv
// One direction of transfer: per-channel word storage and full flags.
module mbox_dir #(
  parameter int unsigned CH = mbox_pkg::MB_CH,
  parameter int unsigned DW = mbox_pkg::MB_DW,
  localparam int unsigned IW = $clog2(CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_word,
  output logic [CH-1:0] full
);
  logic [DW-1:0] mem [CH];
  logic          accept;

  assign accept  = wr_en && !full[wr_idx];
  assign rd_word = mem[rd_idx];

  // storage without reset so it maps onto memory
  always_ff @(posedge clk) begin
    if (accept) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= '0;
    end else begin
      if (accept) full[wr_idx] <= 1'b1;
      if (rd_en && full[rd_idx]) full[rd_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_side.sv
// Register port of one side: decode, control word, doorbells, read mux, irq.
module mbox_side #(
  parameter int unsigned CH  = mbox_pkg::MB_CH,
  parameter int unsigned DW  = mbox_pkg::MB_DW,
  parameter int unsigned AW  = mbox_pkg::MB_AW,
  parameter int unsigned FLW = mbox_pkg::MB_FLW,
  localparam int unsigned IW = $clog2(CH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel,
  input  logic           wr,
  input  logic           rd,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           irq,
  input  logic [CH-1:0]  tx_full,
  input  logic [CH-1:0]  rx_full,
  input  logic [DW-1:0]  rx_word,
  input  logic [CH-1:0]  peer_ring,
  input  logic [FLW-1:0] peer_flags,
  output logic           tx_wr_en,
  output logic [IW-1:0]  idx,
  output logic           rx_rd_en,
  output logic [CH-1:0]  ring_out,
  output logic [FLW-1:0] flags_out
);
  localparam int unsigned PD_TOP = DW - 1;
  localparam int unsigned FL_TOP = PD_TOP - CH;
  localparam int unsigned EM_TOP = FL_TOP - CH;
  localparam int unsigned RQ_TOP = EM_TOP - CH;
  localparam logic [AW-1:0] A_IN = AW'(CH);
  localparam logic [AW-1:0] A_ST = AW'(2 * CH);
  localparam logic [AW-1:0] A_CT = AW'(2 * CH + 1);

  logic [CH-1:0]  en_pend, en_full, en_empty, pend;
  logic           spare;
  logic [FLW-1:0] flags_q;
  logic           do_wr, do_rd, ct_wr, st_wr;
  logic [DW-1:0]  st_word, ct_word;

  assign do_wr    = sel && wr;
  assign do_rd    = sel && rd;
  assign ct_wr    = do_wr && (addr == A_CT);
  assign st_wr    = do_wr && (addr == A_ST);
  assign idx      = addr[IW-1:0];
  assign tx_wr_en = do_wr && (addr < A_IN);
  assign rx_rd_en = do_rd && (addr >= A_IN) && (addr < A_ST);
  assign flags_out = flags_q;

  genvar g;
  generate
    for (g = 0; g < CH; g++) begin : g_ch
      assign ring_out[g] = ct_wr && wdata[RQ_TOP-g];

      always_ff @(posedge clk) begin
        if (rst) begin
          en_pend[g]  <= 1'b0;
          en_full[g]  <= 1'b0;
          en_empty[g] <= 1'b0;
          pend[g]     <= 1'b0;
        end else begin
          if (ct_wr) begin
            en_pend[g]  <= wdata[PD_TOP-g];
            en_full[g]  <= wdata[FL_TOP-g];
            en_empty[g] <= wdata[EM_TOP-g];
          end
          if (peer_ring[g])                    pend[g] <= 1'b1;
          else if (st_wr && wdata[PD_TOP-g])   pend[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      spare   <= 1'b0;
      flags_q <= '0;
    end else if (ct_wr) begin
      spare   <= wdata[FLW];
      flags_q <= wdata[FLW-1:0];
    end
  end

  always_comb begin
    st_word = '0;
    ct_word = '0;
    for (int n = 0; n < CH; n++) begin
      st_word[PD_TOP-n] = pend[n];
      st_word[FL_TOP-n] = rx_full[n];
      st_word[EM_TOP-n] = ~tx_full[n];
      ct_word[PD_TOP-n] = en_pend[n];
      ct_word[FL_TOP-n] = en_full[n];
      ct_word[EM_TOP-n] = en_empty[n];
    end
    st_word[FLW-1:0] = peer_flags;
    ct_word[FLW]     = spare;
    ct_word[FLW-1:0] = flags_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (do_rd) begin
        if (rx_rd_en)          rdata <= rx_word;
        else if (addr == A_ST) rdata <= st_word;
        else if (addr == A_CT) rdata <= ct_word;
        else                   rdata <= '0;
      end
      irq <= |(rx_full & en_full) | |(~tx_full & en_empty) | |(pend & en_pend);
    end
  end
endmodule

// File: rtl/mbox_unit.sv
module mbox_unit #(
  parameter int unsigned CH  = mbox_pkg::MB_CH,
  parameter int unsigned DW  = mbox_pkg::MB_DW,
  parameter int unsigned AW  = mbox_pkg::MB_AW,
  parameter int unsigned FLW = mbox_pkg::MB_FLW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_sel,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_sel,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam int unsigned IW = $clog2(CH);

  logic [CH-1:0]  ab_full, ba_full, a_ring, b_ring;
  logic [DW-1:0]  ab_word, ba_word;
  logic [IW-1:0]  a_idx, b_idx;
  logic           a_txw, a_rxr, b_txw, b_rxr;
  logic [FLW-1:0] a_flags, b_flags;

  mbox_dir #(.CH(CH), .DW(DW)) u_ab (
    .clk(clk), .rst(rst), .wr_en(a_txw), .wr_idx(a_idx), .wr_data(a_wdata),
    .rd_en(b_rxr), .rd_idx(b_idx), .rd_word(ab_word), .full(ab_full));

  mbox_dir #(.CH(CH), .DW(DW)) u_ba (
    .clk(clk), .rst(rst), .wr_en(b_txw), .wr_idx(b_idx), .wr_data(b_wdata),
    .rd_en(a_rxr), .rd_idx(a_idx), .rd_word(ba_word), .full(ba_full));

  mbox_side #(.CH(CH), .DW(DW), .AW(AW), .FLW(FLW)) u_sa (
    .clk(clk), .rst(rst), .sel(a_sel), .wr(a_wr), .rd(a_rd), .addr(a_addr),
    .wdata(a_wdata), .rdata(a_rdata), .irq(a_irq), .tx_full(ab_full),
    .rx_full(ba_full), .rx_word(ba_word), .peer_ring(b_ring),
    .peer_flags(b_flags), .tx_wr_en(a_txw), .idx(a_idx), .rx_rd_en(a_rxr),
    .ring_out(a_ring), .flags_out(a_flags));

  mbox_side #(.CH(CH), .DW(DW), .AW(AW), .FLW(FLW)) u_sb (
    .clk(clk), .rst(rst), .sel(b_sel), .wr(b_wr), .rd(b_rd), .addr(b_addr),
    .wdata(b_wdata), .rdata(b_rdata), .irq(b_irq), .tx_full(ba_full),
    .rx_full(ab_full), .rx_word(ab_word), .peer_ring(a_ring),
    .peer_flags(a_flags), .tx_wr_en(b_txw), .idx(b_idx), .rx_rd_en(b_rxr),
    .ring_out(b_ring), .flags_out(b_flags));
endmodule

// File: rtl/mbox_unit_chk.sv
module mbox_unit_chk #(
  parameter int unsigned CH = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          a_sel,
  input logic          a_wr,
  input logic          a_rd,
  input logic [AW-1:0] a_addr,
  input logic          b_sel,
  input logic          b_wr,
  input logic          b_rd,
  input logic [AW-1:0] b_addr,
  input logic [DW-1:0] a_rdata,
  input logic [DW-1:0] b_rdata,
  input logic          a_irq,
  input logic          b_irq,
  input logic [CH-1:0] ab_full,
  input logic [CH-1:0] ba_full
);
  // R1: state leaving reset
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (ab_full == '0 && ba_full == '0 && !a_irq && !b_irq && a_rdata == '0));

  // R2: read data holds when no read is made
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(a_sel && a_rd) |=> $stable(a_rdata));

  genvar g;
  generate
    for (g = 0; g < CH; g++) begin : g_ch
      // R3: a full flag rises only after a write to that outgoing register
      a_r3_full_source: assert property (@(posedge clk) disable iff (rst)
        $rose(ab_full[g]) |-> $past(a_sel && a_wr && a_addr == AW'(g)));
      // R4: a full flag falls only after the peer reads that incoming register
      a_r4_full_drain: assert property (@(posedge clk) disable iff (rst)
        $fell(ba_full[g]) |-> $past(a_sel && a_rd && a_addr == AW'(CH + g)));
      // R5: a full slot stays full until it is read
      a_r5_full_held: assert property (@(posedge clk) disable iff (rst)
        (ab_full[g] && !(b_sel && b_rd && b_addr == AW'(CH + g))) |=> ab_full[g]);
    end
  endgenerate
endmodule

bind mbox_unit mbox_unit_chk #(.CH(CH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .a_sel(a_sel), .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr),
  .b_sel(b_sel), .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr),
  .a_rdata(a_rdata), .b_rdata(b_rdata), .a_irq(a_irq), .b_irq(b_irq),
  .ab_full(ab_full), .ba_full(ba_full));

// File: tb/sim_mbox_unit.sv
module sim_mbox_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_sel = 0, a_wr = 0, a_rd = 0, b_sel = 0, b_wr = 0, b_rd = 0;
  logic [3:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  mbox_unit u0 (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input bit side, input logic [3:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (side) begin b_sel = 1; b_wr = 1; b_addr = ad; b_wdata = d; end
    else      begin a_sel = 1; a_wr = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
  endtask

  task automatic bus_rd(input bit side, input logic [3:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (side) begin b_sel = 1; b_rd = 1; b_addr = ad; end
    else      begin a_sel = 1; a_rd = 1; a_addr = ad; end
    @(negedge clk);
    a_sel = 0; a_rd = 0; b_sel = 0; b_rd = 0;
    d = side ? b_rdata : a_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r, pat;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    chk("R1 a_rdata", a_rdata, 32'h0);
    chk("R1 irq", {30'b0, a_irq, b_irq}, 32'h0);
    bus_rd(0, 4'd8, r); chk("R1 A status", r, 32'h00F0_0000);
    bus_rd(1, 4'd9, r); chk("R1 B control", r, 32'h0);
    repeat (3) @(negedge clk);
    chk("R2 rdata held", b_rdata, 32'h0);

    // Sweep: both directions, every channel
    for (int d = 0; d < 2; d++) begin
      for (int ch = 0; ch < 4; ch++) begin
        bit src = d[0];
        bit dst = ~d[0];
        pat = 32'h5A00_0000 + 32'(d) * 32'h0013_0000 + 32'(ch) * 32'h0000_1111 + 32'h7;
        bus_wr(src, 4'(ch), pat);
        bus_rd(src, 4'd8, r);
        chk("R3 writer empty cleared", {28'b0, r[23:20]}, {28'b0, 4'hF & ~(4'b1000 >> ch)});
        bus_rd(dst, 4'd8, r);
        chk("R3 peer full set", {28'b0, r[27:24]}, {28'b0, 4'b1000 >> ch});
        bus_wr(src, 4'(ch), ~pat);
        bus_rd(dst, 4'(4 + ch), r);
        chk("R5 first word kept", r, pat);
        bus_rd(dst, 4'd8, r);
        chk("R4 peer full cleared", {28'b0, r[27:24]}, 32'h0);
        bus_rd(src, 4'd8, r);
        chk("R4 writer empty set", {28'b0, r[23:20]}, 32'h0000_000F);
      end
    end

    // R7 receive interrupt on B, channel 2 (enable bit 25)
    bus_wr(1, 4'd9, 32'h0200_0000);
    @(negedge clk);
    chk("R7 b_irq idle", {31'b0, b_irq}, 32'h0);
    bus_wr(0, 4'd2, 32'hCAFE_0002);
    @(negedge clk);
    chk("R7 b_irq on full", {31'b0, b_irq}, 32'h1);
    bus_rd(1, 4'd6, r);
    @(negedge clk);
    chk("R7 b_irq after read", {31'b0, b_irq}, 32'h0);

    // R7 transmit-empty interrupt on A, channel 1 (enable bit 22)
    bus_wr(0, 4'd9, 32'h0040_0000);
    @(negedge clk);
    chk("R7 a_irq on empty", {31'b0, a_irq}, 32'h1);
    bus_wr(0, 4'd1, 32'h1111_0001);
    @(negedge clk);
    chk("R7 a_irq while full", {31'b0, a_irq}, 32'h0);
    bus_rd(1, 4'd5, r);
    chk("R3 ch1 word", r, 32'h1111_0001);
    bus_wr(0, 4'd9, 32'h0);
    @(negedge clk);
    chk("R7 a_irq disabled", {31'b0, a_irq}, 32'h0);

    // R6/R8/R9: A rings channel 3 (bit 16), spare bit set, flags 5
    bus_wr(0, 4'd9, 32'h0001_000D);
    bus_rd(0, 4'd9, r);
    chk("R9 A control readback", r, 32'h0000_000D);
    bus_rd(1, 4'd8, r);
    chk("R6 R8 B status", r, 32'h10F0_0005);
    bus_wr(1, 4'd9, 32'h1000_0000);
    @(negedge clk);
    chk("R7 b_irq doorbell", {31'b0, b_irq}, 32'h1);
    bus_wr(1, 4'd8, 32'h1000_0000);
    bus_rd(1, 4'd8, r);
    chk("R6 pending cleared", r, 32'h00F0_0005);
    @(negedge clk);
    chk("R7 b_irq doorbell cleared", {31'b0, b_irq}, 32'h0);

    // R9/R6/R8 from B: all ones
    bus_wr(1, 4'd9, 32'hFFFF_FFFF);
    bus_rd(1, 4'd9, r);
    chk("R9 B control readback", r, 32'hFFF0_000F);
    bus_rd(0, 4'd8, r);
    chk("R6 R8 A status", r, 32'hF0F0_0007);
    bus_rd(0, 4'd10, r);
    chk("R2 unmapped reads zero", r, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule